// File: doc/BRIEF.md
# Pixel Threshold Trim Calibration Sequencer

This block equalises comparator thresholds across a pixel array. On request it sweeps a shared reference step code upward through eight levels, one level per edge of the calibration clock. Every pixel watches its own comparator. The first time a pixel's comparator changes state during the sweep, that pixel stores the step code that caused the change in its own trim register.

After the sweep the block drives each stored trim code out, and the array uses it as that pixel's offset selection in normal operation. A pixel that never responds gets the top code and a flag that marks it as uncalibrated. The analog reference generator and the comparators sit outside this block. Comparator outputs arrive asynchronously, and the block synchronises them internally.

Top module: `thresholdTrimSequencer`

## Requirements
- R1: While rstN is low, and after it is released with calStart low, stepCode, calActive, calDone, all trimCode fields and all notCal bits are 0.
- R2: A calStart seen at a calClk edge while idle or done begins a sweep. calActive is 1 for the next 8 cycles, and stepCode reads 0 in the first of them and rises by 1 per cycle to 7. A calStart seen while a sweep or its flush is in progress is ignored, and the step sequence continues unchanged.
- R3: Each comparator passes through two synchroniser flops. The level sampled at a calClk edge belongs to the stepCode shown in the cycle that ends at that edge. The level sampled at the start edge is the pre-sweep baseline. A pixel's transition is a sample that differs from the sample before it, and the pixel's trim field then takes that step code.
- R4: Only a pixel's first transition in a sweep is stored. Later toggles in the same sweep, and any toggles after the sweep, leave its trim field unchanged.
- R5: A pixel with no transition during the sweep has trim field 7 and notCal bit 1 once calDone is high. A pixel that had a transition has notCal 0.
- R6: calActive is 0 from the 9th cycle after the start edge. calDone is 0 up to the 11th edge after the start edge and 1 from that edge on. calDone and all trim and notCal values then hold until the next accepted calStart.
- R7: An accepted calStart clears every trim field to 0, every notCal bit to 0 and calDone to 0 at the start edge.
- R8: trimCode carries pixel i in bits [3i+2:3i], and notCal and cmpRaw carry pixel i in bit i.
- R9: Pixels are independent. Any number of pixels may register a transition on the same step, and each stores that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| calClk | input | 1 | Calibration clock; one sweep step per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| calStart | input | 1 | Request to begin a calibration sweep |
| cmpRaw | input | NUM_PIX | Asynchronous comparator outputs, one per pixel |
| stepCode | output | 3 | Current reference step for the reference generator |
| calActive | output | 1 | High while the reference is being swept |
| calDone | output | 1 | High once all trim codes are final |
| trimCode | output | NUM_PIX*3 | Stored per-pixel offset selection codes |
| notCal | output | NUM_PIX | Per-pixel flag: no transition seen in the last sweep |

## Verification
Two operations can land on the same pixel in back-to-back or shared cycles. The first is the capture of a transition seen on the last step. The second is the end-of-sweep fill that writes the top code into pixels that never responded. The bench makes pixels flip exactly on step 7, alongside pixels that never flip. It then expects code 7 with notCal 0 for the first group and code 7 with notCal 1 for the second. A calStart pulse driven into the middle of a running sweep also coincides with normal stepping, and the bench judges it by an unbroken stepCode sequence and unchanged final codes.

// File: rtl/trimCalPkg.sv
package trimCalPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWEEP = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DONE  = 2'd3
  } calState_t;

  // strobes from the sweep control to the per-pixel datapath
  typedef struct packed {
    logic clearAll;     // accepted start: wipe codes and flags
    logic sweepSample;  // current cycle belongs to a sweep step
    logic finalize;     // last cycle before done: fill unresolved pixels
  } calStrobe_t;

  localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/calSweepCtrl.sv
module calSweepCtrl
  import trimCalPkg::*;
#(
  parameter int NUM_STEPS = 8,
  parameter int CODE_W    = $clog2(NUM_STEPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              calStart,
  output logic [CODE_W-1:0] stepCode,
  output logic              calActive,
  output logic              calDone,
  output calStrobe_t        strobe
);

  localparam logic [CODE_W-1:0] LAST_STEP = CODE_W'(NUM_STEPS - 1);
  localparam logic [CODE_W-1:0] STEP_ONE  = CODE_W'(1);
  // pipeline slack so the last step's sample reaches the latches
  localparam logic [1:0]        FLUSH_LAST = 2'(SYNC_STAGES);

  calState_t         state;
  logic [CODE_W-1:0] stepCnt;
  logic [1:0]        flushCnt;
  logic              startOk;

  assign startOk = calStart && (state == ST_IDLE || state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stepCnt  <= '0;
      flushCnt <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (startOk) begin
            state   <= ST_SWEEP;
            stepCnt <= '0;
          end
        end
        ST_SWEEP: begin
          if (stepCnt == LAST_STEP) begin
            state    <= ST_FLUSH;
            flushCnt <= '0;
          end else begin
            stepCnt <= stepCnt + STEP_ONE;
          end
        end
        ST_FLUSH: begin
          if (flushCnt == FLUSH_LAST) state <= ST_DONE;
          else                        flushCnt <= flushCnt + 2'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign stepCode           = stepCnt;
  assign calActive          = (state == ST_SWEEP);
  assign calDone            = (state == ST_DONE);
  assign strobe.clearAll    = startOk;
  assign strobe.sweepSample = (state == ST_SWEEP);
  assign strobe.finalize    = (state == ST_FLUSH) && (flushCnt == FLUSH_LAST);

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SWEEP && stepCnt != LAST_STEP) |=> (stepCnt == $past(stepCnt) + STEP_ONE)); // R2

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SWEEP && stepCnt != LAST_STEP && calStart) |=> (state == ST_SWEEP)); // R2

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (calDone && !calStart) |=> calDone); // R6

endmodule

// File: rtl/pixelTrimCell.sv
module pixelTrimCell
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearAll,
  input  logic              finalize,
  input  logic              sampleValid,
  input  logic [CODE_W-1:0] sampleStep,
  input  logic              cmpRaw,
  output logic [CODE_W-1:0] trim,
  output logic              notCal
);

  localparam logic [CODE_W-1:0] MAX_CODE = '1;

  logic syncA, syncB, syncPrev;
  logic captured;
  logic hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncA    <= cmpRaw;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign hit = sampleValid && (syncB != syncPrev) && !captured;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trim     <= '0;
      notCal   <= 1'b0;
      captured <= 1'b0;
    end else if (clearAll) begin
      trim     <= '0;
      notCal   <= 1'b0;
      captured <= 1'b0;
    end else if (hit) begin
      trim     <= sampleStep;
      captured <= 1'b1;
    end else if (finalize && !captured) begin
      trim     <= MAX_CODE;
      notCal   <= 1'b1;
      captured <= 1'b1;
    end
  end

  AST_FIRST_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (captured && !clearAll) |=> $stable(trim)); // R4

  AST_NOTCAL_CODE: assert property (@(posedge clk) disable iff (!rstN)
    notCal |-> (trim == MAX_CODE)); // R5

  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    clearAll |=> (trim == '0 && !notCal)); // R7

endmodule

// File: rtl/pixelTrimBank.sv
module pixelTrimBank
  import trimCalPkg::*;
#(
  parameter int NUM_PIX = 16,
  parameter int CODE_W  = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  calStrobe_t                strobe,
  input  logic [CODE_W-1:0]         stepCode,
  input  logic [NUM_PIX-1:0]        cmpRaw,
  output logic [NUM_PIX*CODE_W-1:0] trimFlat,
  output logic [NUM_PIX-1:0]        notCalFlat
);

  // step code and valid travel alongside the comparator synchronisers
  logic [CODE_W-1:0] stepPipe [SYNC_STAGES];
  logic              validPipe [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) begin
        stepPipe[s]  <= '0;
        validPipe[s] <= 1'b0;
      end
    end else begin
      stepPipe[0]  <= stepCode;
      validPipe[0] <= strobe.sweepSample;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        stepPipe[s]  <= stepPipe[s-1];
        validPipe[s] <= validPipe[s-1];
      end
    end
  end

  for (genvar p = 0; p < NUM_PIX; p++) begin : g_pix
    pixelTrimCell #(.CODE_W(CODE_W)) u_cell (
      .clk        (clk),
      .rstN       (rstN),
      .clearAll   (strobe.clearAll),
      .finalize   (strobe.finalize),
      .sampleValid(validPipe[SYNC_STAGES-1]),
      .sampleStep (stepPipe[SYNC_STAGES-1]),
      .cmpRaw     (cmpRaw[p]),
      .trim       (trimFlat[p*CODE_W +: CODE_W]),
      .notCal     (notCalFlat[p])
    );
  end

endmodule

// File: rtl/thresholdTrimSequencer.sv
module thresholdTrimSequencer
  import trimCalPkg::*;
#(
  parameter  int NUM_PIX   = 16,
  parameter  int NUM_STEPS = 8,
  localparam int CODE_W    = $clog2(NUM_STEPS)
) (
  input  logic                      calClk,
  input  logic                      rstN,
  input  logic                      calStart,
  input  logic [NUM_PIX-1:0]        cmpRaw,
  output logic [CODE_W-1:0]         stepCode,
  output logic                      calActive,
  output logic                      calDone,
  output logic [NUM_PIX*CODE_W-1:0] trimCode,
  output logic [NUM_PIX-1:0]        notCal
);

  calStrobe_t strobe;

  calSweepCtrl #(.NUM_STEPS(NUM_STEPS), .CODE_W(CODE_W)) u_ctrl (
    .clk      (calClk),
    .rstN     (rstN),
    .calStart (calStart),
    .stepCode (stepCode),
    .calActive(calActive),
    .calDone  (calDone),
    .strobe   (strobe)
  );

  pixelTrimBank #(.NUM_PIX(NUM_PIX), .CODE_W(CODE_W)) u_bank (
    .clk       (calClk),
    .rstN      (rstN),
    .strobe    (strobe),
    .stepCode  (stepCode),
    .cmpRaw    (cmpRaw),
    .trimFlat  (trimCode),
    .notCalFlat(notCal)
  );

  AST_ACTIVE_DONE_EXCL: assert property (@(posedge calClk) disable iff (!rstN)
    !(calActive && calDone)); // R6

endmodule

// File: tb/thresholdTrimSequencer_bench.sv
module thresholdTrimSequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;
  localparam int CW = 3;

  logic            calClk = 1'b0;
  logic            rstN = 1'b0;
  logic            calStart = 1'b0;
  logic [NP-1:0]   cmpRaw = '0;
  logic [CW-1:0]   stepCode;
  logic            calActive, calDone;
  logic [NP*CW-1:0] trimCode;
  logic [NP-1:0]   notCal;

  int total = 0;
  int fails = 0;
  int flipAt [NP];
  int backAt [NP];
  logic baseLv [NP];

  thresholdTrimSequencer #(.NUM_PIX(NP), .NUM_STEPS(8)) u_thresholdTrimSequencer (
    .calClk(calClk), .rstN(rstN), .calStart(calStart), .cmpRaw(cmpRaw),
    .stepCode(stepCode), .calActive(calActive), .calDone(calDone),
    .trimCode(trimCode), .notCal(notCal)
  );

  always #(CLK_PERIOD/2) calClk = ~calClk;

  function automatic int expTrim(int f);
    return (f < 8) ? f : 7;
  endfunction

  function automatic logic cmpLevel(logic b, int f, int g, int k);
    return b ^ (k >= f) ^ (k >= g);
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic runSweep(bit pokeStart);
    logic [NP*CW-1:0] held;
    logic [NP-1:0]    heldFlag;
    @(negedge calClk);
    for (int i = 0; i < NP; i++) cmpRaw[i] = baseLv[i];
    calStart = 1'b1;
    @(negedge calClk);
    calStart = 1'b0;
    chk("R7", int'(trimCode == '0), 1, "codes cleared at start");
    chk("R7", int'(notCal), 0, "flags cleared at start");
    chk("R7", int'(calDone), 0, "done cleared at start");
    for (int k = 0; k < 8; k++) begin
      chk("R2", int'(stepCode), k, "step code in sweep");
      chk("R2", int'(calActive), 1, "active in sweep");
      for (int i = 0; i < NP; i++) cmpRaw[i] = cmpLevel(baseLv[i], flipAt[i], backAt[i], k);
      calStart = (pokeStart && k == 3);
      @(negedge calClk);
    end
    calStart = 1'b0;
    chk("R6", int'(calActive), 0, "active drops after step 7");
    @(negedge calClk);
    @(negedge calClk);
    chk("R6", int'(calDone), 0, "done not yet before 11th edge");
    @(negedge calClk);
    chk("R6", int'(calDone), 1, "done at 11th edge");
    for (int i = 0; i < NP; i++) begin
      chk("R3", int'(trimCode[i*CW +: CW]), expTrim(flipAt[i]), $sformatf("trim pixel %0d", i));
      chk("R5", int'(notCal[i]), int'(flipAt[i] >= 8), $sformatf("notCal pixel %0d", i));
    end
    held = trimCode;
    heldFlag = notCal;
    for (int c = 0; c < 5; c++) begin
      cmpRaw = NP'($urandom);
      @(negedge calClk);
    end
    chk("R4", int'(trimCode == held), 1, "codes hold after sweep despite toggles");
    chk("R6", int'(notCal == heldFlag), 1, "flags hold after sweep");
    chk("R6", int'(calDone), 1, "done holds");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    total++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge calClk);
    chk("R1", int'(trimCode == '0 && notCal == '0), 1, "codes zero in reset");
    chk("R1", int'(calDone || calActive), 0, "status low in reset");
    rstN = 1'b1;
    @(negedge calClk);
    @(negedge calClk);
    chk("R1", int'(stepCode), 0, "step zero after reset");
    chk("R1", int'(calDone), 0, "done low after reset");

    // R9: every pixel on step 0
    for (int i = 0; i < NP; i++) begin flipAt[i] = 0; backAt[i] = 99; baseLv[i] = 1'b0; end
    runSweep(1'b0);
    // R5: no pixel ever flips
    for (int i = 0; i < NP; i++) begin flipAt[i] = 8; backAt[i] = 99; baseLv[i] = 1'(i); end
    runSweep(1'b0);
    // last-step capture next to end-of-sweep fill (R5, R9)
    for (int i = 0; i < NP; i++) begin flipAt[i] = (i % 2) ? 7 : 8; backAt[i] = 99; baseLv[i] = 1'b1; end
    runSweep(1'b0);
    // R4: flip then flip back next step; R8 layout by distinct per-pixel steps
    for (int i = 0; i < NP; i++) begin flipAt[i] = i % 7; backAt[i] = (i % 7) + 1; baseLv[i] = 1'b0; end
    runSweep(1'b0);
    // random runs; one with a start pulse mid-sweep (R2)
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < NP; i++) begin
        flipAt[i] = int'($urandom % 9);
        backAt[i] = flipAt[i] + 1 + int'($urandom % 8);
        baseLv[i] = 1'($urandom);
      end
      runSweep(r == 2);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule